// File: doc/BRIEF.md
# Washing Machine Cycle Controller

This block sequences a washing machine through three working programs (wash, rinse and dry) from a standby state. In standby a program and a run time in minutes and seconds are captured from a configuration strobe. A start request then launches the selected program. The remaining time counts down in BCD, one step per second. When the time reaches zero the machine returns to standby on its own and raises a one-cycle done pulse. A running cycle can be paused and resumed, and a stop request aborts it at any time.

The one-second step comes from a parameterised clock divider. The motor is driven by two direction lines, pulse-width modulated from a free-running counter. The duty depends on the program: wash runs forward at medium duty, rinse runs in reverse at low duty and dry runs forward at high duty. Display outputs present either the stored preset or the live countdown, selected by the machine state.

Top module: `wm_cycle_ctrl`

## Requirements
- R1: After reset the block is in standby: mode_code is 000, disp_sel, done, all indicators and both motor lines are 0, and the stored preset is 01:00 with no program selected (disp_mode 000).
- R2: A cfg_load pulse in standby stores the program (cfg_prog: 01 wash, 10 rinse, 11 dry, 00 none) and a clamped time. A units digit above 9 counts as 9 and a seconds-tens digit above 5 counts as 5. A whole-minute value of 60 or more becomes 60:00, and a value under one minute becomes 01:00. In standby the disp_* outputs show the stored preset and disp_mode shows {0, program}.
- R3: cfg_load has no effect while running or paused. After a later stop, the display still shows the earlier preset and program.
- R4: start in standby with program 00 is ignored. With a program set, the block enters the working state on the next clock. mode_code becomes 001, 010 or 011 for wash, rinse or dry, exactly the matching indicator is high, and disp_sel is 1.
- R5: While working, the displayed time drops by one second every TICK_DIV clocks of running time. Seconds borrow from 0 to 59, and minutes borrow from tens of minutes.
- R6: When the count reaches 00:00 while working, the next clock returns the block to standby and asserts done for exactly one cycle.
- R7: pause while working gives mode_code 100, turns off the indicators and motor lines, and freezes the count and the divider phase. A later start resumes the same program from the frozen time and phase.
- R8: stop from any state gives standby and both motor lines low on the next clock, and the display shows the stored preset.
- R9: Over any 256 clocks of steady running, wash drives motor_fwd high for 64 clocks, rinse drives motor_rev high for 16 and dry drives motor_fwd high for 128. motor_fwd and motor_rev are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture program and time (standby only) |
| cfg_prog | input | 2 | Program select: 01 wash, 10 rinse, 11 dry |
| cfg_min_tens | input | 4 | Preset tens of minutes |
| cfg_min_ones | input | 4 | Preset minutes |
| cfg_sec_tens | input | 4 | Preset tens of seconds |
| cfg_sec_ones | input | 4 | Preset seconds |
| start | input | 1 | Start from standby, or resume from pause |
| pause | input | 1 | Pause a running cycle |
| stop | input | 1 | Abort to standby |
| mode_code | output | 3 | Current mode: 000 standby, 001 wash, 010 rinse, 011 dry, 100 paused |
| ind_wash | output | 1 | Wash active |
| ind_rinse | output | 1 | Rinse active |
| ind_dry | output | 1 | Dry active |
| disp_sel | output | 1 | 1: live values shown, 0: preset shown |
| disp_mode | output | 3 | Mode shown on the display |
| disp_min_tens | output | 4 | Displayed tens of minutes |
| disp_min_ones | output | 4 | Displayed minutes |
| disp_sec_tens | output | 4 | Displayed tens of seconds |
| disp_sec_ones | output | 4 | Displayed seconds |
| done | output | 1 | One-cycle pulse on countdown expiry |
| motor_fwd | output | 1 | Forward drive, PWM |
| motor_rev | output | 1 | Reverse drive, PWM |

## Verification
The hardest situation to reach is a pause that lands mid-way through a one-second divider period, followed by a resume. The count must then step at the cycle the divider phase dictates, neither restarted nor skipped. The stimulus counts running clocks exactly: it pauses a few clocks after a step, waits far longer than a period, resumes, and checks the time one clock before and at the expected step. Full expiry and borrow across digit boundaries are reached with a small TICK_DIV. Randomly drawn presets and programs from a seeded generator cover clamping and short countdowns.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef logic [3:0] bcd_t;

  typedef struct packed {
    bcd_t min_t;
    bcd_t min_u;
    bcd_t sec_t;
    bcd_t sec_u;
  } run_time_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} state_t;

  typedef enum logic [1:0] {
    PRG_NONE  = 2'b00,
    PRG_WASH  = 2'b01,
    PRG_RINSE = 2'b10,
    PRG_DRY   = 2'b11
  } prog_t;

  localparam logic [2:0] CODE_IDLE = 3'b000;
  localparam logic [2:0] CODE_HOLD = 3'b100;
  localparam run_time_t  TIME_MIN  = '{min_t: 4'd0, min_u: 4'd1, sec_t: 4'd0, sec_u: 4'd0};
  localparam run_time_t  TIME_MAX  = '{min_t: 4'd6, min_u: 4'd0, sec_t: 4'd0, sec_u: 4'd0};

  function automatic bcd_t sat_digit(bcd_t d, bcd_t lim);
    return (d > lim) ? lim : d;
  endfunction

  // Limit a raw preset to the legal range 01:00 .. 60:00
  function automatic run_time_t clamp_time(run_time_t raw);
    run_time_t  r;
    logic [7:0] mins;
    r.min_t = raw.min_t;
    r.min_u = sat_digit(raw.min_u, 4'd9);
    r.sec_t = sat_digit(raw.sec_t, 4'd5);
    r.sec_u = sat_digit(raw.sec_u, 4'd9);
    mins    = {4'd0, r.min_t} * 8'd10 + {4'd0, r.min_u};
    if (mins >= 8'd60)     r = TIME_MAX;
    else if (mins == 8'd0) r = TIME_MIN;
    return r;
  endfunction
endpackage

// File: rtl/wm_tick_gen.sv
module wm_tick_gen #(
  parameter int TICK_DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LIM = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (en)     cnt_q <= (cnt_q == LIM) ? '0 : cnt_q + 1'b1;
  end

  // R7: divider phase holds while not enabled
  a_r7_phase_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/wm_bcd_down.sv
module wm_bcd_down
  import wm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  run_time_t load_val,
  input  logic      dec,
  output run_time_t cnt,
  output logic      zero
);
  localparam int NDIG = 4;
  // wrap value per digit, least significant first: sec units, sec tens, min units, min tens
  localparam logic [4*NDIG-1:0] WRAP = {4'd9, 4'd9, 4'd5, 4'd9};

  logic [4*NDIG-1:0] cur_q, nxt;
  logic [NDIG-1:0]   brw;

  assign cnt    = run_time_t'(cur_q);
  assign zero   = (cur_q == '0);
  assign brw[0] = dec && !zero;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    logic [3:0] d;
    assign d = cur_q[g*4 +: 4];
    assign nxt[g*4 +: 4] = brw[g] ? ((d == 4'd0) ? WRAP[g*4 +: 4] : d - 4'd1) : d;
    if (g < NDIG - 1) begin : g_brw
      assign brw[g+1] = brw[g] && (d == 4'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       cur_q <= TIME_MIN;
    else if (load) cur_q <= load_val;
    else           cur_q <= nxt;
  end

  // R7: without a step or load the count is frozen
  a_r7_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (!dec && !load) |=> $stable(cur_q));
  // R5: every digit stays a legal time digit
  a_r5_digits_legal: assert property (@(posedge clk) disable iff (rst)
    (cnt.sec_u <= 4'd9) && (cnt.sec_t <= 4'd5) && (cnt.min_u <= 4'd9) && (cnt.min_t <= 4'd6));
  // R5: a step from a nonzero count changes it
  a_r5_step_moves: assert property (@(posedge clk) disable iff (rst)
    (dec && !zero && !load) |=> !$stable(cur_q));
endmodule

// File: rtl/wm_motor_drive.sv
module wm_motor_drive
  import wm_pkg::*;
#(
  parameter int PWM_W = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  enable,
  input  prog_t prog,
  output logic  fwd,
  output logic  rev
);
  localparam logic [PWM_W-1:0] THR_SLOW = PWM_W'(1) << (PWM_W - 4);
  localparam logic [PWM_W-1:0] THR_MED  = PWM_W'(1) << (PWM_W - 2);
  localparam logic [PWM_W-1:0] THR_FAST = PWM_W'(1) << (PWM_W - 1);

  logic [PWM_W-1:0] pwm_q;
  logic [PWM_W-1:0] thr;
  logic             on, want_fwd, want_rev;

  always_comb begin
    unique case (prog)
      PRG_WASH:  thr = THR_MED;
      PRG_RINSE: thr = THR_SLOW;
      PRG_DRY:   thr = THR_FAST;
      default:   thr = '0;
    endcase
  end

  assign on       = enable && (pwm_q < thr);
  assign want_fwd = on && ((prog == PRG_WASH) || (prog == PRG_DRY));
  assign want_rev = on && (prog == PRG_RINSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= '0;
      fwd   <= 1'b0;
      rev   <= 1'b0;
    end else begin
      pwm_q <= pwm_q + 1'b1;
      fwd   <= want_fwd;
      rev   <= want_rev;
    end
  end

  // R9: never both directions
  a_r9_dir_exclusive: assert property (@(posedge clk) disable iff (rst) !(fwd && rev));
  // R8: drive removed one clock after enable drops
  a_r8_drive_off: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!fwd && !rev));
endmodule

// File: rtl/wm_cycle_ctrl.sv
module wm_cycle_ctrl
  import wm_pkg::*;
#(
  parameter int TICK_DIV = 100_000_000,
  parameter int PWM_W    = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_load,
  input  logic [1:0] cfg_prog,
  input  logic [3:0] cfg_min_tens,
  input  logic [3:0] cfg_min_ones,
  input  logic [3:0] cfg_sec_tens,
  input  logic [3:0] cfg_sec_ones,
  input  logic       start,
  input  logic       pause,
  input  logic       stop,
  output logic [2:0] mode_code,
  output logic       ind_wash,
  output logic       ind_rinse,
  output logic       ind_dry,
  output logic       disp_sel,
  output logic [2:0] disp_mode,
  output logic [3:0] disp_min_tens,
  output logic [3:0] disp_min_ones,
  output logic [3:0] disp_sec_tens,
  output logic [3:0] disp_sec_ones,
  output logic       done,
  output logic       motor_fwd,
  output logic       motor_rev
);
  state_t    state_q, state_d;
  prog_t     prog_q;
  run_time_t preset_q, live, shown, raw_cfg;
  logic      done_q, tick, zero, is_idle, is_run, motor_en, expire;

  assign is_idle = (state_q == ST_IDLE);
  assign is_run  = (state_q == ST_RUN);
  assign expire  = is_run && zero;
  assign raw_cfg = '{min_t: cfg_min_tens, min_u: cfg_min_ones,
                     sec_t: cfg_sec_tens, sec_u: cfg_sec_ones};

  // Next-state: stop wins, then expiry, then pause/start
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (!stop && start && (prog_q != PRG_NONE)) state_d = ST_RUN;
      ST_RUN: begin
        if (stop || zero) state_d = ST_IDLE;
        else if (pause)   state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (stop)       state_d = ST_IDLE;
        else if (start) state_d = ST_RUN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      prog_q   <= PRG_NONE;
      preset_q <= TIME_MIN;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= expire && !stop;
      if (is_idle && cfg_load) begin
        prog_q   <= prog_t'(cfg_prog);
        preset_q <= clamp_time(raw_cfg);
      end
    end
  end

  wm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (is_idle),
    .en   (is_run),
    .tick (tick)
  );

  wm_bcd_down u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (is_idle),
    .load_val (preset_q),
    .dec      (tick),
    .cnt      (live),
    .zero     (zero)
  );

  assign motor_en = is_run && !stop && !pause && !zero;

  wm_motor_drive #(.PWM_W(PWM_W)) u_motor (
    .clk    (clk),
    .rst    (rst),
    .enable (motor_en),
    .prog   (prog_q),
    .fwd    (motor_fwd),
    .rev    (motor_rev)
  );

  always_comb begin
    unique case (state_q)
      ST_RUN:  mode_code = {1'b0, prog_q};
      ST_HOLD: mode_code = CODE_HOLD;
      default: mode_code = CODE_IDLE;
    endcase
  end

  assign ind_wash      = is_run && (prog_q == PRG_WASH);
  assign ind_rinse     = is_run && (prog_q == PRG_RINSE);
  assign ind_dry       = is_run && (prog_q == PRG_DRY);
  assign disp_sel      = !is_idle;
  assign shown         = disp_sel ? live : preset_q;
  assign disp_mode     = disp_sel ? mode_code : {1'b0, prog_q};
  assign disp_min_tens = shown.min_t;
  assign disp_min_ones = shown.min_u;
  assign disp_sec_tens = shown.sec_t;
  assign disp_sec_ones = shown.sec_u;
  assign done          = done_q;

  // R2: stored preset always inside 01:00 .. 60:00
  a_r2_preset_range: assert property (@(posedge clk) disable iff (rst)
    (preset_q.min_t < 4'd6 && (preset_q.min_t != 4'd0 || preset_q.min_u != 4'd0))
    || (preset_q == TIME_MAX));
  // R3: settings locked outside standby
  a_r3_preset_locked: assert property (@(posedge clk) disable iff (rst)
    !is_idle |=> ($stable(preset_q) && $stable(prog_q)));
  // R8: stop reaches standby in one clock
  a_r8_stop_idle: assert property (@(posedge clk) disable iff (rst)
    stop |=> (mode_code == CODE_IDLE));
  // R6: done is a single-cycle pulse seen in standby
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (mode_code == CODE_IDLE));
  // R4: at most one indicator
  a_r4_ind_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ind_wash, ind_rinse, ind_dry}));
endmodule

// File: tb/wm_cycle_ctrl_tb_top.sv
module wm_cycle_ctrl_tb_top;
  localparam int DIV = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_prog = 2'b00;
  logic [3:0] c_mt = 4'd0, c_mu = 4'd0, c_st = 4'd0, c_su = 4'd0;
  logic       start = 1'b0, pause = 1'b0, stop = 1'b0;
  logic [2:0] mode_code, disp_mode;
  logic       ind_wash, ind_rinse, ind_dry, disp_sel, done, motor_fwd, motor_rev;
  logic [3:0] d_mt, d_mu, d_st, d_su;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wm_cycle_ctrl #(.TICK_DIV(DIV), .PWM_W(8)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_prog(cfg_prog),
    .cfg_min_tens(c_mt), .cfg_min_ones(c_mu), .cfg_sec_tens(c_st), .cfg_sec_ones(c_su),
    .start(start), .pause(pause), .stop(stop),
    .mode_code(mode_code), .ind_wash(ind_wash), .ind_rinse(ind_rinse), .ind_dry(ind_dry),
    .disp_sel(disp_sel), .disp_mode(disp_mode),
    .disp_min_tens(d_mt), .disp_min_ones(d_mu), .disp_sec_tens(d_st), .disp_sec_ones(d_su),
    .done(done), .motor_fwd(motor_fwd), .motor_rev(motor_rev)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int shown();
    return {d_mt, d_mu, d_st, d_su};
  endfunction

  // Model of the preset clamp, written from R2 in seconds
  function automatic int model_clamp(int mt, int mu, int st, int su);
    int m = mt * 10 + ((mu > 9) ? 9 : mu);
    int s = ((st > 5) ? 5 : st) * 10 + ((su > 9) ? 9 : su);
    if (m >= 60) return 16'h6000;
    if (m == 0)  return 16'h0100;
    return ((m / 10) << 12) | ((m % 10) << 8) | ((s / 10) << 4) | (s % 10);
  endfunction

  // Model of a countdown of k seconds (R5)
  function automatic int model_after(int t, int k);
    int secs = (((t >> 12) & 15) * 10 + ((t >> 8) & 15)) * 60 + ((t >> 4) & 15) * 10 + (t & 15) - k;
    int m, s;
    if (secs < 0) secs = 0;
    m = secs / 60; s = secs % 60;
    return ((m / 10) << 12) | ((m % 10) << 8) | ((s / 10) << 4) | (s % 10);
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cfg(input int prog, input int mt, input int mu, input int st, input int su);
    cfg_prog = 2'(prog); c_mt = 4'(mt); c_mu = 4'(mu); c_st = 4'(st); c_su = 4'(su);
    cfg_load = 1'b1; cyc(1); cfg_load = 1'b0;
  endtask

  task automatic press_start(); start = 1'b1; cyc(1); start = 1'b0; endtask
  task automatic press_pause(); pause = 1'b1; cyc(1); pause = 1'b0; endtask
  task automatic press_stop();  stop  = 1'b1; cyc(1); stop  = 1'b0; endtask

  task automatic run_check(input int prog, input int mt, input int mu, input int st, input int su, input int k);
    int pre = model_clamp(mt, mu, st, su);
    load_cfg(prog, mt, mu, st, su);
    chk(shown() == pre, "R2", "preset display", shown(), pre);
    chk(disp_mode == 3'(prog), "R2", "preset program", disp_mode, prog);
    press_start();
    chk(mode_code == 3'(prog) && disp_sel, "R4", "running mode code", mode_code, prog);
    chk({ind_wash, ind_rinse, ind_dry} == ((prog == 1) ? 3'b100 : (prog == 2) ? 3'b010 : 3'b001),
        "R4", "indicators", {ind_wash, ind_rinse, ind_dry}, prog);
    cyc(k * DIV - 1);
    chk(shown() == model_after(pre, k - 1), "R5", "no early step", shown(), model_after(pre, k - 1));
    cyc(1);
    chk(shown() == model_after(pre, k), "R5", "countdown value", shown(), model_after(pre, k));
    press_stop();
    chk(mode_code == 3'b000 && !motor_fwd && !motor_rev, "R8", "stop to standby", mode_code, 0);
    chk(shown() == pre && !disp_sel, "R8", "preset shown after stop", shown(), pre);
  endtask

  task automatic motor_check(input int prog, input int exp_f, input int exp_r);
    int nf = 0, nr = 0, nb = 0;
    load_cfg(prog, 0, 5, 0, 0);
    press_start();
    cyc(2);
    for (int i = 0; i < 256; i++) begin
      nf += int'(motor_fwd); nr += int'(motor_rev); nb += int'(motor_fwd && motor_rev);
      cyc(1);
    end
    chk(nf == exp_f, "R9", "forward duty", nf, exp_f);
    chk(nr == exp_r, "R9", "reverse duty", nr, exp_r);
    chk(nb == 0, "R9", "directions exclusive", nb, 0);
    press_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nf, nr;
    void'($urandom(32'd2024));
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(mode_code == 3'b000 && !disp_sel && !done, "R1", "reset mode", mode_code, 0);
    chk({ind_wash, ind_rinse, ind_dry, motor_fwd, motor_rev} == 5'b0, "R1", "reset outputs",
        {ind_wash, ind_rinse, ind_dry, motor_fwd, motor_rev}, 0);
    chk(shown() == 16'h0100 && disp_mode == 3'b000, "R1", "reset preset", shown(), 16'h0100);

    // R4 start without a program is ignored
    press_start();
    chk(mode_code == 3'b000 && !disp_sel, "R4", "start with no program", mode_code, 0);

    // R2 directed clamps
    load_cfg(1, 0, 0, 0, 0);    chk(shown() == 16'h0100, "R2", "00:00 clamp", shown(), 16'h0100);
    load_cfg(1, 0, 0, 5, 9);    chk(shown() == 16'h0100, "R2", "00:59 clamp", shown(), 16'h0100);
    load_cfg(1, 6, 0, 0, 1);    chk(shown() == 16'h6000, "R2", "60:01 clamp", shown(), 16'h6000);
    load_cfg(1, 7, 5, 0, 0);    chk(shown() == 16'h6000, "R2", "75:00 clamp", shown(), 16'h6000);
    load_cfg(1, 3, 10, 5, 15);  chk(shown() == 16'h3959, "R2", "digit saturate", shown(), 16'h3959);
    load_cfg(2, 1, 2, 7, 9);    chk(shown() == 16'h1259, "R2", "sec tens saturate", shown(), 16'h1259);

    // R5 directed borrows
    run_check(1, 1, 0, 0, 0, 1);
    run_check(2, 6, 0, 0, 0, 1);
    run_check(3, 0, 1, 0, 0, 1);
    run_check(1, 2, 0, 0, 3, 5);

    // Random presets and programs
    for (int i = 0; i < 12; i++) begin
      run_check(1 + int'($urandom_range(0, 2)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 1 + int'($urandom_range(0, 4)));
    end

    // R9 motor drive per program
    motor_check(1, 64, 0);
    motor_check(2, 0, 16);
    motor_check(3, 128, 0);

    // R7 pause mid-period, then resume; R3 settings ignored while paused
    load_cfg(2, 0, 2, 0, 0);
    press_start();
    cyc(3 * DIV);
    chk(shown() == 16'h0157, "R5", "three steps", shown(), 16'h0157);
    cyc(3);
    press_pause();
    chk(mode_code == 3'b100 && disp_sel && disp_mode == 3'b100, "R7", "paused code", mode_code, 4);
    chk({ind_wash, ind_rinse, ind_dry} == 3'b0, "R7", "paused indicators", {ind_wash, ind_rinse, ind_dry}, 0);
    load_cfg(3, 3, 0, 0, 0);
    nf = 0; nr = 0;
    for (int i = 0; i < 5 * DIV; i++) begin
      nf += int'(motor_fwd); nr += int'(motor_rev);
      cyc(1);
    end
    chk(nf + nr == 0, "R7", "motor off while paused", nf + nr, 0);
    chk(shown() == 16'h0157, "R7", "count frozen", shown(), 16'h0157);
    press_start();
    chk(mode_code == 3'b010 && ind_rinse, "R7", "resumed program", mode_code, 2);
    cyc(3);
    chk(shown() == 16'h0157, "R7", "phase kept before step", shown(), 16'h0157);
    cyc(1);
    chk(shown() == 16'h0156, "R7", "phase kept at step", shown(), 16'h0156);
    press_stop();
    chk(shown() == 16'h0200 && disp_mode == 3'b010, "R3", "cfg ignored while paused", shown(), 16'h0200);

    // R3 settings ignored while running
    press_start();
    load_cfg(1, 4, 4, 0, 0);
    press_stop();
    chk(shown() == 16'h0200 && disp_mode == 3'b010, "R3", "cfg ignored while running", shown(), 16'h0200);

    // R8 stop from pause
    press_start();
    press_pause();
    press_stop();
    chk(mode_code == 3'b000 && !disp_sel, "R8", "stop from pause", mode_code, 0);

    // R6 full expiry of a clamped 01:00 dry cycle
    load_cfg(3, 0, 0, 2, 0);
    press_start();
    cyc(60 * DIV);
    chk(shown() == 16'h0000 && mode_code == 3'b011 && !done, "R6", "reached zero", shown(), 0);
    cyc(1);
    chk(mode_code == 3'b000 && done, "R6", "standby with done", {mode_code, done}, 1);
    chk(shown() == 16'h0100 && !motor_fwd, "R6", "preset restored", shown(), 16'h0100);
    cyc(1);
    chk(!done, "R6", "done single cycle", done, 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule